// File: doc/BRIEF.md
# SD command path engine

This block issues one command on the single-wire command line of an SD or MMC card and, when asked to, captures the card's reply. Software loads the 32-bit argument, then writes a control word that holds the command index, a host-origin marker and the start bit. The engine builds a 48-bit frame protected by CRC7 and shifts it out MSB first. When the control word requests no reply, the engine finishes there. Otherwise it listens for a 48-bit or 136-bit response and stores the payload in four 32-bit response words.

Progress is reported only through four sticky flags: frame sent, response received, response timeout and response CRC failure. Each flag is cleared by writing a one to it. A free-running prescaler derives the card clock from the system clock. The engine drives frame bits when the card clock falls and samples the card's reply when it rises.

Register offsets on `addr`: 0 prescaler, 1 argument, 2 control, 3 status, 4 to 7 response words 0 to 3. Reads are combinational and have no side effects.

Top module: `sdcmd_engine`

## Requirements
- R1: The card clock period is (prescaler + 1) system clocks, and a prescaler of 0 acts as 1. The prescaler is 8 bits wide (offset 0), so the divider reaches 256, which is enough for a 400 kHz identification clock.
- R2: A control write (offset 2) with bit 8 (start) and bit 6 (host marker) both set, made while idle, starts a command using index bits [5:0]. A write with bit 6 clear starts nothing. Control bit 8 reads 1 while a command is in progress and 0 once the engine is idle again.
- R3: Control writes made while a command is in progress are ignored: the frame being sent and the stored control fields stay unchanged, and no second frame follows.
- R4: The frame is a 0 start bit, a 1 transmission bit, the 6-bit index, the 32-bit argument, CRC7 (polynomial x^7+x^3+1) over the preceding 40 bits, and a 1 end bit. It is sent MSB first. `cmd_oe` is high for exactly the 48 bits, and `cmd_out` changes only when `sd_clk` falls.
- R5: Status bit 11 (sent) is set one card clock after the end bit is driven, for every command. With control bit 9 (expect reply) clear, bit 11 is the only flag set.
- R6: With bit 9 set, a 0 sampled on a rising card-clock edge starts the reply. After 64 rising edges that sample 1, status bit 10 (timeout) is set and nothing is captured. A start bit on the 64th edge after the end bit is still accepted.
- R7: A short reply (bit 10 of control clear) sets status bit 9 and loads reply bits [39:8] into response word 0 (offset 4). Words 1 to 3 keep their values. If reply bits [7:1] differ from the CRC7 of reply bits [47:8], status bit 12 is also set.
- R8: A long reply (control bit 10 set) is 136 bits long and sets status bit 9. Reply bits [127:96], [95:64], [63:32] and [31:0] go to words 0, 1, 2 and 3. The embedded CRC is stored as received and status bit 12 is never set.
- R9: A status write (offset 3) clears each flag at a bit position where the written data is 1 and leaves the others alone. Writing all ones clears every flag.
- R10: After reset every register reads 0, `cmd_oe` is 0 and `cmd_out` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register offset |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data for `addr` |
| sd_clk | output | 1 | Card clock |
| cmd_out | output | 1 | Command line output value |
| cmd_oe | output | 1 | Command line output enable |
| cmd_in | input | 1 | Command line value seen from the card |

## Verification
The hardest case to reach is the edge of the reply window. The bench has to place the card's start bit exactly on the 64th rising card-clock edge after the end bit, then one edge later, and show that the first is accepted and the second ends in a timeout. Its card model waits for `cmd_oe` to fall and then counts a chosen number of falling card-clock edges before it drives the reply. This puts the start bit on a known rising edge for delays of 0, 63 and 64. The same model flips one CRC bit to reach the CRC failure path. A control write issued halfway through a frame exercises the busy-ignore rule.

// File: rtl/sdcmd_engine.sv
module sdcmd_engine #(
  parameter int DIV_W    = 8,
  parameter int TO_LIMIT = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        sd_clk,
  output logic        cmd_out,
  output logic        cmd_oe,
  input  logic        cmd_in
);

  localparam logic [2:0] A_PRE  = 3'd0;
  localparam logic [2:0] A_ARG  = 3'd1;
  localparam logic [2:0] A_CTRL = 3'd2;
  localparam logic [2:0] A_STAT = 3'd3;
  localparam int TW = $clog2(TO_LIMIT + 1);

  typedef enum logic [1:0] {S_IDLE, S_SEND, S_WAIT, S_RECV} st_t;

  function automatic logic [6:0] crc7(input logic [39:0] d);
    logic [6:0] c;
    logic fb;
    c = '0;
    for (int i = 39; i >= 0; i--) begin
      fb = d[i] ^ c[6];
      c  = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return c;
  endfunction

  st_t               state;
  logic [DIV_W-1:0]  pre_q, cnt_q, div, cnt_nx;
  logic [DIV_W:0]    half;
  logic              clk_q, rise_t, fall_t;
  logic [31:0]       arg_q;
  logic [5:0]        idx_q;
  logic              host_q, wrsp_q, long_q;
  logic [47:0]       shreg;
  logic [7:0]        bitcnt;
  logic [TW-1:0]     to_cnt;
  logic [126:0]      rx;
  logic [127:0]      rx_nx;
  logic [31:0]       rsp0, rsp1, rsp2, rsp3;
  logic              st_rsp, st_to, st_sent, st_crc;
  logic              busy, ctrl_go, ctrl_wr, stat_wr;

  // card clock divider
  assign div    = (pre_q == '0) ? {{(DIV_W-1){1'b0}}, 1'b1} : pre_q;
  assign cnt_nx = (cnt_q >= div) ? '0 : cnt_q + 1'b1;
  assign half   = ({1'b0, div} + 1'b1) >> 1;
  assign rise_t = (cnt_nx == '0);
  assign fall_t = ({1'b0, cnt_nx} == half);
  assign sd_clk = clk_q;

  assign busy    = (state != S_IDLE);
  assign ctrl_wr = wr_en && (addr == A_CTRL);
  assign stat_wr = wr_en && (addr == A_STAT);
  assign ctrl_go = ctrl_wr && !busy && wdata[8] && wdata[6];
  assign rx_nx   = {rx, cmd_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q   <= '0;
      cnt_q   <= '0;
      clk_q   <= 1'b0;
      arg_q   <= '0;
      idx_q   <= '0;
      host_q  <= 1'b0;
      wrsp_q  <= 1'b0;
      long_q  <= 1'b0;
      shreg   <= '0;
      bitcnt  <= '0;
      to_cnt  <= '0;
      rx      <= '0;
      rsp0    <= '0;
      rsp1    <= '0;
      rsp2    <= '0;
      rsp3    <= '0;
      st_rsp  <= 1'b0;
      st_to   <= 1'b0;
      st_sent <= 1'b0;
      st_crc  <= 1'b0;
      cmd_out <= 1'b1;
      cmd_oe  <= 1'b0;
      state   <= S_IDLE;
    end else begin
      cnt_q <= cnt_nx;
      clk_q <= ({1'b0, cnt_nx} < half);
      if (wr_en && addr == A_PRE) pre_q <= wdata[DIV_W-1:0];
      if (wr_en && addr == A_ARG) arg_q <= wdata;
      if (ctrl_wr && !busy) begin
        idx_q  <= wdata[5:0];
        host_q <= wdata[6];
        wrsp_q <= wdata[9];
        long_q <= wdata[10];
      end
      if (stat_wr) begin
        if (wdata[9])  st_rsp  <= 1'b0;
        if (wdata[10]) st_to   <= 1'b0;
        if (wdata[11]) st_sent <= 1'b0;
        if (wdata[12]) st_crc  <= 1'b0;
      end
      case (state)
        S_IDLE: begin
          if (ctrl_go) begin
            shreg  <= {2'b01, wdata[5:0], arg_q,
                       crc7({2'b01, wdata[5:0], arg_q}), 1'b1};
            bitcnt <= '0;
            state  <= S_SEND;
          end
        end
        S_SEND: begin
          if (fall_t) begin
            if (bitcnt == 8'd48) begin
              cmd_oe  <= 1'b0;
              cmd_out <= 1'b1;
              st_sent <= 1'b1;
              to_cnt  <= '0;
              state   <= wrsp_q ? S_WAIT : S_IDLE;
            end else begin
              cmd_oe  <= 1'b1;
              cmd_out <= shreg[47];
              shreg   <= {shreg[46:0], 1'b0};
              bitcnt  <= bitcnt + 8'd1;
            end
          end
        end
        S_WAIT: begin
          if (rise_t) begin
            if (!cmd_in) begin
              rx     <= rx_nx[126:0];
              bitcnt <= 8'd1;
              state  <= S_RECV;
            end else if (to_cnt == TW'(TO_LIMIT - 1)) begin
              st_to <= 1'b1;
              state <= S_IDLE;
            end else begin
              to_cnt <= to_cnt + 1'b1;
            end
          end
        end
        S_RECV: begin
          if (rise_t) begin
            rx     <= rx_nx[126:0];
            bitcnt <= bitcnt + 8'd1;
            if (bitcnt == (long_q ? 8'd135 : 8'd47)) begin
              st_rsp <= 1'b1;
              state  <= S_IDLE;
              if (long_q) begin
                rsp0 <= rx_nx[127:96];
                rsp1 <= rx_nx[95:64];
                rsp2 <= rx_nx[63:32];
                rsp3 <= rx_nx[31:0];
              end else begin
                rsp0 <= rx_nx[39:8];
                if (crc7(rx_nx[47:8]) != rx_nx[7:1]) st_crc <= 1'b1;
              end
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    case (addr)
      A_PRE:   rdata = {{(32-DIV_W){1'b0}}, pre_q};
      A_ARG:   rdata = arg_q;
      A_CTRL:  rdata = {21'b0, long_q, wrsp_q, busy, 1'b0, host_q, idx_q};
      A_STAT:  rdata = {19'b0, st_crc, st_sent, st_to, st_rsp, 9'b0};
      3'd4:    rdata = rsp0;
      3'd5:    rdata = rsp1;
      3'd6:    rdata = rsp2;
      default: rdata = rsp3;
    endcase
  end

  assert_start_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !busy && wdata[8] && wdata[6]) |=> (state == S_SEND));

  assert_busy_ignore_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && busy) |=> ($stable(idx_q) && $stable(long_q) && $stable(wrsp_q)));

  assert_edge_align_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cmd_out) |-> $fell(sd_clk));

  assert_sent_from_send_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_sent) |-> ($past(state) == S_SEND));

  assert_wait_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT) |-> (to_cnt < TW'(TO_LIMIT)));

  assert_crc_with_rsp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_crc) |-> (st_rsp && !long_q));

endmodule

// File: tb/sim_sdcmd_engine.sv
module sim_sdcmd_engine;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        sd_clk, cmd_out, cmd_oe;
  logic        cmd_in = 1'b1;

  int checks = 0;
  int errors = 0;
  int nframes = 0;
  logic [31:0] exp_w [4];

  always #2 clk = ~clk;

  sdcmd_engine u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .sd_clk(sd_clk), .cmd_out(cmd_out), .cmd_oe(cmd_oe),
    .cmd_in(cmd_in)
  );

  always @(posedge cmd_oe) nframes++;

  // {idx[47:42], arg[41:10], expect reply[9], long[8], delay[7:1], bad crc[0]}
  localparam logic [47:0] VEC [7] = '{
    {6'd2,  32'h0000_0000, 1'b1, 1'b1, 7'd3,  1'b0},
    {6'd17, 32'h1234_5678, 1'b1, 1'b0, 7'd0,  1'b0},
    {6'd0,  32'h0000_0000, 1'b0, 1'b0, 7'd0,  1'b0},
    {6'd55, 32'hFFFF_FFFF, 1'b1, 1'b0, 7'd63, 1'b0},
    {6'd8,  32'hCAFE_0001, 1'b1, 1'b0, 7'd64, 1'b0},
    {6'd13, 32'h0BAD_C0DE, 1'b1, 1'b0, 7'd5,  1'b1},
    {6'd63, 32'hA5A5_0F0F, 1'b1, 1'b1, 7'd10, 1'b0}
  };

  function automatic logic [6:0] ref_crc(input logic [39:0] d);
    logic [46:0] r;
    r = {d, 7'b0};
    for (int i = 46; i >= 7; i--)
      if (r[i]) r[i -: 8] = r[i -: 8] ^ 8'h89;
    return r[6:0];
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] d;
    for (int i = 0; i < 4000; i++) begin
      rd(3'd2, d);
      if (!d[8]) break;
    end
  endtask

  task automatic cap48(output logic [47:0] f);
    f = '0;
    @(posedge cmd_oe);
    for (int i = 0; i < 48; i++) begin
      @(posedge sd_clk);
      f = {f[46:0], cmd_out};
    end
  endtask

  task automatic card(input int dly, input logic [135:0] fr, input int n);
    @(negedge cmd_oe);
    repeat (dly) @(negedge sd_clk);
    for (int i = n - 1; i >= 0; i--) begin
      cmd_in = fr[i];
      @(negedge sd_clk);
    end
    cmd_in = 1'b1;
  endtask

  task automatic period(output int p);
    logic last;
    @(posedge sd_clk);
    @(negedge clk);
    last = sd_clk;
    p = 0;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      p++;
      if (sd_clk && !last) break;
      last = sd_clk;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog act=running exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [47:0] f, ef;
    logic [135:0] rf;
    int p, n0;

    exp_w = '{default: '0};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      chk("R10", "reset register", 64'(d), 64'd0);
    end
    chk("R10", "reset cmd_oe", 64'(cmd_oe), 64'd0);
    chk("R10", "reset cmd_out", 64'(cmd_out), 64'd1);

    // R1 prescaler
    wr(3'd0, 32'd3);  period(p); period(p);
    chk("R1", "period pre=3", 64'(p), 64'd4);
    wr(3'd0, 32'd9);  period(p); period(p);
    chk("R1", "period pre=9", 64'(p), 64'd10);
    wr(3'd0, 32'd0);  period(p); period(p);
    chk("R1", "period pre=0", 64'(p), 64'd2);
    wr(3'd0, 32'd1);

    // vector table
    foreach (VEC[v]) begin
      logic [5:0]  idx;
      logic [31:0] arg, ctrl, pay, es;
      logic        wt, lg, bad;
      int          dly;
      logic [31:0] w [4];
      idx = VEC[v][47:42]; arg = VEC[v][41:10];
      wt = VEC[v][9]; lg = VEC[v][8]; dly = int'(VEC[v][7:1]); bad = VEC[v][0];
      ef = {2'b01, idx, arg, ref_crc({2'b01, idx, arg}), 1'b1};
      rf = '0;
      if (lg) begin
        w[0] = arg; w[1] = ~arg; w[2] = arg ^ 32'h0F0F_F0F0;
        w[3] = {arg[15:0] ^ 16'hBEEF, 8'h5A, 8'h23};
        rf = {2'b00, 6'h3F, w[0], w[1], w[2], w[3]};
      end else begin
        pay = arg ^ 32'hC3C3_3C3C;
        rf[47:0] = {2'b00, idx, pay, ref_crc({2'b00, idx, pay}) ^ {6'b0, bad}, 1'b1};
        w = exp_w; w[0] = pay;
      end
      ctrl = (32'(lg) << 10) | (32'(wt) << 9) | 32'h140 | 32'(idx);
      wr(3'd1, arg);
      fork
        cap48(f);
        begin if (wt) card(dly, rf, lg ? 136 : 48); end
        wr(3'd2, ctrl);
      join
      wait_idle();
      chk("R4", "frame", 64'(f), 64'(ef));
      es = 32'h800;
      if (wt) begin
        if (dly < 64) begin
          es |= 32'h200;
          if (bad && !lg) es |= 32'h1000;
          exp_w = w;
        end else es |= 32'h400;
      end
      rd(3'd3, d);
      chk(wt ? (dly < 64 ? (lg ? "R8" : "R7") : "R6") : "R5", "status", 64'(d), 64'(es));
      for (int k = 0; k < 4; k++) begin
        rd(3'(4 + k), d);
        chk(lg ? "R8" : "R7", "response word", 64'(d), 64'(exp_w[k]));
      end
      wr(3'd3, 32'h800);
      rd(3'd3, d);
      chk("R9", "partial clear", 64'(d), 64'(es & ~32'h800));
      wr(3'd3, 32'hFFFF_FFFF);
      rd(3'd3, d);
      chk("R9", "clear all", 64'(d), 64'd0);
    end

    // R2 host marker clear: no command
    n0 = nframes;
    wr(3'd2, 32'h105);
    repeat (300) @(negedge clk);
    chk("R2", "no frame without host bit", 64'(nframes), 64'(n0));
    rd(3'd3, d);
    chk("R2", "no status without host bit", 64'(d), 64'd0);
    rd(3'd2, d);
    chk("R2", "start reads 0 when idle", 64'(d[8]), 64'd0);

    // R3 control write while busy
    wr(3'd1, 32'h0000_7777);
    ef = {2'b01, 6'd9, 32'h0000_7777, ref_crc({2'b01, 6'd9, 32'h0000_7777}), 1'b1};
    n0 = nframes;
    fork
      cap48(f);
      begin
        wr(3'd2, 32'h149);
        repeat (20) @(negedge clk);
        rd(3'd2, d);
        chk("R2", "start reads 1 while busy", 64'(d[8]), 64'd1);
        wr(3'd2, 32'h761);
      end
    join
    wait_idle();
    chk("R3", "frame unchanged", 64'(f), 64'(ef));
    rd(3'd2, d);
    chk("R3", "control fields kept", 64'(d), 64'h49);
    repeat (300) @(negedge clk);
    chk("R3", "single frame", 64'(nframes), 64'(n0 + 1));
    rd(3'd3, d);
    chk("R5", "sent only", 64'(d), 64'h800);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule